// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration fabric. It turns host
accesses to two small ports into configuration requests for the functions on
bus 0. The first port holds a 32-bit selector register that software loads
with one full-width write. The second port is a 4-byte data window. Reads and
writes of 1, 2 or 4 bytes at any byte lane of the window are checked against
the selector. If the checks pass, the access goes out as a single-cycle
request that names the target function, the register offset, the length and
the write data.

The selector register has this layout:

| Bits  | Meaning                                             |
|-------|-----------------------------------------------------|
| 31    | Enable bit                                          |
| 23:16 | Bus number                                          |
| 15:8  | Function address (devfn)                            |
| 7:2   | Dword index                                         |
| 1:0   | Must be zero for the window to be usable            |

Within the devfn field, the device number is devfn[7:3] and the function
number is devfn[2:0]. A presence vector with one bit per devfn tells the
bridge which functions exist. Accesses to missing functions, and accesses
that fail any check, never reach the fabric. Reads of such accesses return
all ones for the accessed width.

The host sees read data one cycle after the access. The fabric must answer a
request with read data in the same cycle that the request is presented.

Top module: `cfgp_bridge`

## Requirements
- R1: The selector register resets to 0. It loads host_wdata only on a write to the address port (host_sel_data=0) with size code 2 (4 bytes) and host_ofs=0; any other address-port write leaves it unchanged. A 4-byte read of the address port returns the register unchanged.
- R2: A data-port access (host_sel_data=1) raises cfg_req only when selector bit 31 is 1.
- R3: A data-port access raises cfg_req only when selector bits 1:0 are both 0.
- R4: A data-port access raises cfg_req only when selector bits 23:16 (the bus number) are 0.
- R5: cfg_devfn equals selector bits 15:8, and a request is raised only when fn_present[cfg_devfn] is 1.
- R6: cfg_reg equals selector bits 7:2 in cfg_reg[7:2] and host_ofs in cfg_reg[1:0].
- R7: The size code gives the width: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. cfg_len carries the size code. Code 3 is never forwarded.
- R8: host_rvalid is 1 exactly in the cycle after a read access. host_rdata then holds one of two values: cfg_rdata masked to the access width for a forwarded read, or all ones over that width (with the upper bits 0) for a read that is not forwarded. Code 3, and any address-port read that is not 4 bytes, return 32'hFFFF_FFFF.
- R9: Data is right-justified and little-endian: the byte at the lowest offset is in bits 7:0. cfg_wdata is host_wdata masked to the access width, and cfg_we follows host_write. A write that is not forwarded raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_sel_data | input | 1 | 0 = address port, 1 = data window |
| host_ofs | input | 2 | Byte offset within the port |
| host_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=illegal |
| host_wdata | input | 32 | Right-justified host write data |
| host_rdata | output | 32 | Read data returned to the host |
| host_rvalid | output | 1 | host_rdata valid, one cycle after a read |
| fn_present | input | 256 | One bit per devfn; 1 = function exists |
| cfg_req | output | 1 | Configuration request strobe |
| cfg_we | output | 1 | Request is a write |
| cfg_devfn | output | 8 | Target devfn |
| cfg_reg | output | 8 | Target register byte offset |
| cfg_len | output | 2 | Size code of the request |
| cfg_wdata | output | 32 | Write data masked to the access width |
| cfg_rdata | input | 32 | Same-cycle read data from the function |

## Verification
A corrupted selector register appears at the ports on the very next access. A 4-byte address-port read returns the wrong word, and the next data access goes to the wrong devfn or offset, or is wrongly dropped. A fault in the gating shows up in the cycle of the access itself: cfg_req is raised or not raised for the wrong combination of enable bit, low bits, bus number and presence bit. A fault in read data shows up one cycle later, as wrong width masking or a missing all-ones pattern. The sweeps cover every devfn and every register byte offset at every legal width.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int DATA_W   = 32;
  localparam int DEVFN_W  = 8;
  localparam int NUM_FN   = 1 << DEVFN_W;
  localparam int EN_BIT   = 31;
  localparam int BUS_LSB  = 16;
  localparam int BUS_W    = 8;
  localparam int FN_LSB   = 8;
  localparam int REG_W    = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] addr_q
);
  logic [DATA_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (wr_en) addr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(addr_q));
endmodule

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_data,
  input  logic [DATA_W-1:0]  addr_q,
  input  logic [1:0]         ofs,
  input  logic [1:0]         size,
  input  logic [NUM_FN-1:0]  present,
  output logic               fwd,
  output logic [DEVFN_W-1:0] devfn,
  output logic [REG_W-1:0]   reg_ofs
);
  logic en_ok, align_ok, bus_ok, size_ok, fn_ok;

  always_comb begin
    devfn    = addr_q[FN_LSB +: DEVFN_W];
    reg_ofs  = {addr_q[REG_W-1:2], ofs};
    en_ok    = addr_q[EN_BIT];
    align_ok = (addr_q[1:0] == 2'b00);
    bus_ok   = (addr_q[BUS_LSB +: BUS_W] == '0);
    size_ok  = (size != SZ_BAD);
    fn_ok    = present[devfn];
    fwd      = acc_data && en_ok && align_ok && bus_ok && size_ok && fn_ok;
  end

  // R2
  req_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> addr_q[EN_BIT]);
  // R3
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (addr_q[1:0] == 2'b00));
  // R4
  req_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (addr_q[BUS_LSB +: BUS_W] == '0));
  // R5
  req_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> present[devfn]);
  // R7
  req_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (size != SZ_BAD));
endmodule

// File: rtl/cfgp_rdata.sv
module cfgp_rdata
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              sel_addr,
  input  logic              fwd,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] addr_q,
  input  logic [DATA_W-1:0] fn_rdata,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask = size_mask(size);
    if (sel_addr)
      rdata_d = (size == SZ_WORD) ? addr_q : 32'hFFFF_FFFF;
    else if (fwd)
      rdata_d = fn_rdata & mask;
    else
      rdata_d = mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_stb;
      if (rd_stb) rdata_q <= rdata_d;
    end
  end

  // R8
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rvalid_q);
  // R8
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rvalid_q);
endmodule

// File: rtl/cfgp_bridge.sv
module cfgp_bridge
  import cfgp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic               host_write,
  input  logic               host_sel_data,
  input  logic [1:0]         host_ofs,
  input  logic [1:0]         host_size,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  input  logic [NUM_FN-1:0]  fn_present,
  output logic               cfg_req,
  output logic               cfg_we,
  output logic [DEVFN_W-1:0] cfg_devfn,
  output logic [REG_W-1:0]   cfg_reg,
  output logic [1:0]         cfg_len,
  output logic [DATA_W-1:0]  cfg_wdata,
  input  logic [DATA_W-1:0]  cfg_rdata
);
  logic [DATA_W-1:0] addr_q;
  logic              addr_wr, data_acc, rd_stb, fwd;

  always_comb begin
    addr_wr  = host_valid && host_write && !host_sel_data &&
               (host_size == SZ_WORD) && (host_ofs == 2'b00);
    data_acc = host_valid && host_sel_data;
    rd_stb   = host_valid && !host_write;
  end

  cfgp_addr_reg u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(addr_wr), .wdata(host_wdata),
    .addr_q(addr_q)
  );

  cfgp_decode u_dec (
    .clk(clk), .rst_n(rst_n), .acc_data(data_acc), .addr_q(addr_q),
    .ofs(host_ofs), .size(host_size), .present(fn_present),
    .fwd(fwd), .devfn(cfg_devfn), .reg_ofs(cfg_reg)
  );

  cfgp_rdata u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .sel_addr(!host_sel_data),
    .fwd(fwd), .size(host_size), .addr_q(addr_q), .fn_rdata(cfg_rdata),
    .rdata_q(host_rdata), .rvalid_q(host_rvalid)
  );

  always_comb begin
    cfg_req   = fwd;
    cfg_we    = host_write;
    cfg_len   = host_size;
    cfg_wdata = host_wdata & size_mask(host_size);
  end

  // R9
  wdata_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && host_size == SZ_BYTE) |-> (cfg_wdata[DATA_W-1:8] == '0));
  // R1
  addr_port_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_sel_data) |-> !cfg_req);
endmodule

// File: tb/tb_cfgp_bridge.sv
module tb_cfgp_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_valid, host_write, host_sel_data;
  logic [1:0]  host_ofs, host_size;
  logic [31:0] host_wdata, host_rdata, cfg_wdata, cfg_rdata;
  logic        host_rvalid, cfg_req, cfg_we;
  logic [255:0] fn_present;
  logic [7:0]  cfg_devfn, cfg_reg;
  logic [1:0]  cfg_len;

  int total = 0;
  int fails = 0;

  logic        s_req, s_we, s_rv;
  logic [7:0]  s_devfn, s_reg;
  logic [1:0]  s_len;
  logic [31:0] s_wd, s_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgp_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_sel_data(host_sel_data), .host_ofs(host_ofs), .host_size(host_size),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .fn_present(fn_present), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg), .cfg_len(cfg_len),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [31:0] fn_model(input logic [7:0] d, input logic [7:0] r);
    return {d, r, d ^ 8'hFF, r ^ 8'h5A};
  endfunction

  function automatic logic [31:0] wmask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] sel(input logic en, input logic [7:0] bus,
                                      input logic [7:0] d, input logic [5:0] dw,
                                      input logic [1:0] lo);
    return {en, 7'b0, bus, d, dw, lo};
  endfunction

  always_comb cfg_rdata = fn_model(cfg_devfn, cfg_reg);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic sd, input logic we, input logic [1:0] ofs,
                     input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    host_valid = 1'b1; host_write = we; host_sel_data = sd;
    host_ofs = ofs; host_size = sz; host_wdata = wd;
    #1;
    s_req = cfg_req; s_we = cfg_we; s_devfn = cfg_devfn; s_reg = cfg_reg;
    s_len = cfg_len; s_wd = cfg_wdata;
    @(negedge clk);
    host_valid = 1'b0;
    s_rv = host_rvalid; s_rd = host_rdata;
  endtask

  task automatic set_sel(input logic [31:0] v);
    acc(1'b0, 1'b1, 2'd0, 2'd2, v);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    host_valid = 0; host_write = 0; host_sel_data = 0;
    host_ofs = 0; host_size = 0; host_wdata = 0;
    for (int i = 0; i < 256; i++) fn_present[i] = (i % 3 != 1);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset value
    acc(1'b0, 1'b0, 2'd0, 2'd2, 0);
    chk(s_rv && s_rd == 32'h0, "R1 reset", s_rd, 0);
    // R1 readback
    set_sel(32'h5A3C_0F81);
    acc(1'b0, 1'b0, 2'd0, 2'd2, 0);
    chk(s_rd == 32'h5A3C_0F81, "R1 readback", s_rd, 32'h5A3C_0F81);
    // R1 narrow and offset writes ignored
    acc(1'b0, 1'b1, 2'd0, 2'd0, 32'h11);
    acc(1'b0, 1'b1, 2'd1, 2'd2, 32'h22);
    acc(1'b0, 1'b0, 2'd0, 2'd2, 0);
    chk(s_rd == 32'h5A3C_0F81, "R1 ignore", s_rd, 32'h5A3C_0F81);
    // R8 narrow address-port read gives all ones
    acc(1'b0, 1'b0, 2'd0, 2'd1, 0);
    chk(s_rd == 32'hFFFF_FFFF, "R8 addr narrow", s_rd, 32'hFFFF_FFFF);

    // R2 enable clear
    set_sel(sel(1'b0, 8'd0, 8'd0, 6'd0, 2'd0));
    acc(1'b1, 1'b0, 2'd0, 2'd2, 0);
    chk(!s_req && s_rd == 32'hFFFF_FFFF, "R2 disabled", {31'b0, s_req}, 0);
    // R3 low bits
    for (int lo = 1; lo < 4; lo++) begin
      set_sel(sel(1'b1, 8'd0, 8'd0, 6'd0, lo[1:0]));
      acc(1'b1, 1'b0, 2'd0, 2'd1, 0);
      chk(!s_req && s_rd == 32'hFFFF, "R3 misaligned", s_rd, 32'hFFFF);
    end
    // R4 bus number
    for (int b = 1; b < 256; b = b * 2 + 1) begin
      set_sel(sel(1'b1, b[7:0], 8'd0, 6'd0, 2'd0));
      acc(1'b1, 1'b1, 2'd0, 2'd2, 32'h1234);
      chk(!s_req, "R4 bus nonzero", {31'b0, s_req}, 0);
    end

    // R5 R8 sweep over all devfn
    for (int d = 0; d < 256; d++) begin
      logic p;
      logic [31:0] e;
      p = (d % 3 != 1);
      set_sel(sel(1'b1, 8'd0, d[7:0], 6'd3, 2'd0));
      acc(1'b1, 1'b0, 2'd0, 2'd2, 0);
      e = p ? fn_model(d[7:0], 8'h0C) : 32'hFFFF_FFFF;
      chk(s_req == p, "R5 presence", {31'b0, s_req}, {31'b0, p});
      if (p) chk(s_devfn == d[7:0], "R5 devfn", {24'b0, s_devfn}, d);
      chk(s_rv && s_rd == e, "R8 sweep rdata", s_rd, e);
    end

    // R6 R7 R8 offset and width sweep
    for (int dw = 0; dw < 64; dw++) begin
      set_sel(sel(1'b1, 8'd0, 8'd9, dw[5:0], 2'd0));
      for (int o = 0; o < 4; o++) begin
        for (int sz = 0; sz < 4; sz++) begin
          logic [7:0] r;
          logic [31:0] e;
          r = {dw[5:0], o[1:0]};
          e = (sz == 3) ? 32'hFFFF_FFFF : (fn_model(8'd9, r) & wmask(sz[1:0]));
          acc(1'b1, 1'b0, o[1:0], sz[1:0], 0);
          if (sz == 3) chk(!s_req, "R7 bad size", {31'b0, s_req}, 0);
          else begin
            chk(s_req && s_reg == r, "R6 reg offset", {24'b0, s_reg}, {24'b0, r});
            chk(s_len == sz[1:0], "R7 len", {30'b0, s_len}, sz);
          end
          chk(s_rd == e, "R8 width rdata", s_rd, e);
        end
      end
    end

    // R9 write data little-endian and masked
    set_sel(sel(1'b1, 8'd0, 8'd0, 6'd1, 2'd0));
    for (int sz = 0; sz < 3; sz++) begin
      logic [31:0] e;
      e = 32'hA1B2_C3D4 & wmask(sz[1:0]);
      acc(1'b1, 1'b1, 2'd2, sz[1:0], 32'hA1B2_C3D4);
      chk(s_req && s_we && s_wd == e, "R9 wdata", s_wd, e);
      chk(!s_rv, "R8 no rvalid on write", {31'b0, s_rv}, 0);
    end
    // R9 write to absent function dropped
    set_sel(sel(1'b1, 8'd0, 8'd4, 6'd1, 2'd0));
    acc(1'b1, 1'b1, 2'd0, 2'd2, 32'hDEAD_BEEF);
    chk(!s_req, "R9 dropped write", {31'b0, s_req}, 0);
    // R8 absent read all ones for byte width
    acc(1'b1, 1'b0, 2'd3, 2'd0, 0);
    chk(s_rd == 32'hFF, "R8 absent byte", s_rd, 32'hFF);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule